// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block merges up to eight internal event lines into one active-low interrupt line that behaves like an open-drain output. Each event pulse sets a bit in a pending-request register. A mask register decides which pending bits may pull the line low. Software removes pending bits one at a time by writing zeros into a separate clear register.

Software reaches the registers through a simple write port: a write enable, a 2-bit register select and a data word. It reads them back through a combinational read port. Reset masks every source, empties the pending register and switches off a small group of error-enable control bits. The CPU bus decoding and the event sources are not part of this block.

Top module: `irq_mask_ctrl`

## Requirements
- R1: `irq_oe_o` is 1, and `irq_n_o` is pulled to 0, exactly when at least one request bit is 1 and its mask bit is 0. Otherwise `irq_oe_o` is 0 and `irq_n_o` is released to high impedance, so an external pull-up reads it as 1.
- R2: An event pulse `evt_i[i]` sets request bit i at the next clock edge whatever the mask bit is. A masked pending bit asserts the output once its mask bit is later written to 0.
- R3: A write to select 2 (clear register) sets request bit i to 0 where data bit i is 0. Where data bit i is 1, request bit i is unchanged.
- R4: If an event and a clear hit the same request bit in the same cycle, the bit is 1 after the edge.
- R5: While `rst_n` is 0, the mask register is all ones, the request register is all zeros and every error-enable bit is 0. The output is therefore released.
- R6: A write to select 1 loads the mask register with the data word. Reading select 1 returns the mask register.
- R7: Reading select 0 returns the request register. A write to select 0 changes no register.
- R8: Reading select 2 returns all ones.
- R9: A write to select 3 loads the error-enable bits from data bits [ERR_W-1:0] (3 bits by default) and drives them on `err_en_o`. Reading select 3 returns them in those bit positions, with zeros above.
- R10: The output stays asserted while any unmasked request bit is still pending, even after other bits have been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | Event pulses, one per source |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | N_SRC | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | N_SRC | Read data (combinational) |
| err_en_o | output | ERR_W | Error-enable control bits |
| irq_oe_o | output | 1 | Pull-down enable of the interrupt line |
| irq_n_o | output | 1 | Open-drain interrupt line: 0 or high impedance |

## Verification
Events and register writes are sampled at a rising edge. The request, mask and error-enable registers take their new value at that same edge. The interrupt line and the read data are combinational from those registers, so every result is due in the cycle that follows the stimulus edge. The bench drives inputs at the falling edge and compares all outputs just before the next falling edge. That way each check sees the state produced by exactly one rising edge. The collision case and the reset case are checked with the same one-edge spacing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_REQ  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_data_i,
    output logic [N_SRC-1:0] req_o
);
    typedef struct packed {
        logic [N_SRC-1:0] req;
    } req_state_t;

    req_state_t st_d, st_q;
    logic [N_SRC-1:0] keep_d;

    always_comb begin
        st_d   = st_q;
        keep_d = clr_we_i ? clr_data_i : '1;
        st_d.req = (st_q.req & keep_d) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit_chk
        // R2
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> req_o[i]);
        // R3
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && !clr_data_i[i] && !evt_i[i]) |=> !req_o[i]);
        // R7
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_we_i && !evt_i[i]) |=> $stable(req_o[i]));
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int N_SRC = 8,
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    input  logic             ctrl_we_i,
    input  logic [ERR_W-1:0] ctrl_wdata_i,
    output logic [N_SRC-1:0] mask_o,
    output logic [ERR_W-1:0] err_en_o
);
    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic [ERR_W-1:0] err_en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we_i) st_d.mask   = mask_wdata_i;
        if (ctrl_we_i) st_d.err_en = ctrl_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask   <= '1;
            st_q.err_en <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o   = st_q.mask;
    assign err_en_o = st_q.err_en;

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));
    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we_i |=> (err_en_o == $past(ctrl_wdata_i)));
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_out_drv.sv
module irq_out_drv #(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic             irq_oe_o,
    output logic             irq_n_o
);
    logic [N_SRC-1:0] live_d;

    always_comb begin
        live_d   = req_i & ~mask_i;
        irq_oe_o = |live_d;
    end

    assign irq_n_o = irq_oe_o ? 1'b0 : 1'bz;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [N_SRC-1:0] rd_data_o,
    output logic [ERR_W-1:0] err_en_o,
    output logic             irq_oe_o,
    output logic             irq_n_o
);
    logic             clr_we, mask_we, ctrl_we;
    logic [N_SRC-1:0] req_q, mask_q;

    always_comb begin
        clr_we  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CLR);
        mask_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);
        ctrl_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
    end

    irq_req_bank #(.N_SRC(N_SRC)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_we_i   (clr_we),
        .clr_data_i (wr_data_i),
        .req_o      (req_q)
    );

    irq_cfg_regs #(.N_SRC(N_SRC), .ERR_W(ERR_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we),
        .mask_wdata_i (wr_data_i),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (wr_data_i[ERR_W-1:0]),
        .mask_o       (mask_q),
        .err_en_o     (err_en_o)
    );

    irq_out_drv #(.N_SRC(N_SRC)) u_out (
        .req_i    (req_q),
        .mask_i   (mask_q),
        .irq_oe_o (irq_oe_o),
        .irq_n_o  (irq_n_o)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (reg_sel_e'(rd_sel_i))
            SEL_REQ:  rd_data_o = req_q;
            SEL_MASK: rd_data_o = mask_q;
            SEL_CLR:  rd_data_o = '1;
            SEL_CTRL: rd_data_o[ERR_W-1:0] = err_en_o;
            default:  rd_data_o = '0;
        endcase
    end

    // R1
    out_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~mask_q) != '0) == irq_oe_o);
    // R4
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (evt_i != '0)) |=> ((req_q & $past(evt_i)) == $past(evt_i)));
    // R5
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && req_q == '0 && err_en_o == '0));
endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 8;
    localparam int ERR_W = 3;
    localparam int VEC_W = 36;
    localparam int N_VEC = 13;

    // fields: evt, we, sel, data, exp_req, exp_mask, exp_oe
    localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
        {8'h01, 1'b0, 2'd0, 8'h00, 8'h01, 8'hFF, 1'b0}, // R2 masked event pends
        {8'h00, 1'b1, 2'd1, 8'hFE, 8'h01, 8'hFE, 1'b1}, // R6 R1 unmask bit0
        {8'h80, 1'b0, 2'd0, 8'h00, 8'h81, 8'hFE, 1'b1}, // R2
        {8'h00, 1'b1, 2'd2, 8'hFE, 8'h80, 8'hFE, 1'b0}, // R3 clear bit0
        {8'h00, 1'b1, 2'd1, 8'h7E, 8'h80, 8'h7E, 1'b1}, // R2 later unmask
        {8'h02, 1'b1, 2'd2, 8'h7D, 8'h02, 8'h7E, 1'b0}, // R4 collision bit1
        {8'h00, 1'b1, 2'd1, 8'h00, 8'h02, 8'h00, 1'b1}, // R6
        {8'h00, 1'b1, 2'd0, 8'hFF, 8'h02, 8'h00, 1'b1}, // R7 write ignored
        {8'h00, 1'b1, 2'd2, 8'hFF, 8'h02, 8'h00, 1'b1}, // R3 ones keep
        {8'h0C, 1'b0, 2'd0, 8'h00, 8'h0E, 8'h00, 1'b1}, // R2
        {8'h00, 1'b1, 2'd2, 8'hFD, 8'h0C, 8'h00, 1'b1}, // R10 still on
        {8'h00, 1'b1, 2'd2, 8'hF3, 8'h00, 8'h00, 1'b0}, // R10 all cleared
        {8'h00, 1'b1, 2'd3, 8'h05, 8'h00, 8'h00, 1'b0}  // R9
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] evt = '0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [N_SRC-1:0] wr_data = '0;
    logic [1:0]       rd_sel = '0;
    logic [N_SRC-1:0] rd_data;
    logic [ERR_W-1:0] err_en;
    logic             irq_oe;
    wire              irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pullup (irq_n);

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl #(.N_SRC(N_SRC), .ERR_W(ERR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .err_en_o  (err_en),
        .irq_oe_o  (irq_oe),
        .irq_n_o   (irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        check(tag, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic out_chk(input string tag, input logic exp_oe);
        check(tag, {31'h0, irq_oe}, {31'h0, exp_oe});
        check(tag, {31'h0, irq_n}, {31'h0, ~exp_oe});
    endtask

    task automatic step(input logic [7:0] e, input logic we, input logic [1:0] sel,
                        input logic [7:0] d);
        @(negedge clk);
        evt = e; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        evt = '0; wr_en = 1'b0;
        @(negedge clk);
        #(-0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5 reset state
        read_chk("R5 mask", 2'd1, 8'hFF);
        read_chk("R5 req", 2'd0, 8'h00);
        check("R5 err", {29'h0, err_en}, 32'h0);
        out_chk("R5 out", 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < N_VEC; k++) begin
            step(VECS[k][35:28], VECS[k][27], VECS[k][26:25], VECS[k][24:17]);
            out_chk($sformatf("R1 vec%0d", k), VECS[k][0]);
            read_chk($sformatf("R7 req vec%0d", k), 2'd0, VECS[k][16:9]);
            read_chk($sformatf("R6 mask vec%0d", k), 2'd1, VECS[k][8:1]);
            read_chk($sformatf("R8 clr vec%0d", k), 2'd2, 8'hFF);
        end

        // R9 readback and upper bits dropped
        read_chk("R9 ctrl", 2'd3, 8'h05);
        check("R9 err_en", {29'h0, err_en}, 32'h5);
        step(8'h00, 1'b1, 2'd3, 8'hFF);
        read_chk("R9 ctrl pad", 2'd3, 8'h07);

        // R4 collision on an unmasked bit
        step(8'h10, 1'b0, 2'd0, 8'h00);
        step(8'h10, 1'b1, 2'd2, 8'h00);
        read_chk("R4 collide", 2'd0, 8'h10);
        out_chk("R4 out", 1'b1);

        // R5 reset mid-run while asserted
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        read_chk("R5 mask again", 2'd1, 8'hFF);
        read_chk("R5 req again", 2'd0, 8'h00);
        check("R5 err again", {29'h0, err_en}, 32'h0);
        out_chk("R5 out again", 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule